// File: doc/BRIEF.md
# Byte-Lane Pipelined Synchronous SRAM

This block is a single-port synchronous static memory with an 18-bit word split into two independent 9-bit byte lanes. Every command input (address, active-low chip enable, active-low write enable and the two active-low lane enables) is captured on the rising clock edge. Reads pass through an output register: the word addressed at edge n is presented after edge n+1. Writes take their data from `dq_in` on the same edge as the address and are committed inside that cycle, with no externally shaped write pulse.

The shared bidirectional data bus of the memory is split into `dq_in`, `dq_out` and a per-lane drive enable `dq_oe`. The drive enable combines a registered "lane was read" flag with the asynchronous, active-low `oe_n`. Pulling `oe_n` high blanks both lanes at once, without waiting for a clock edge. A chip that integrates the block connects `dq_oe` to its pad drivers.

The array depth is set by `ADDR_W`. The full part uses `ADDR_W = 16` (65,536 words). The default of 10 keeps elaboration small.

Top module: `sram_byte_lane`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first read reaches the output register, `dq_oe` is 2'b00.
- R2: A read (`ce_n`=0, `we_n`=1) sampled at edge n shows the addressed word on `dq_out` after edge n+1. It stays valid until edge n+2.
- R3: A write (`ce_n`=0, `we_n`=0, `lane_n`=2'b00) stores all 18 bits of `dq_in`, as sampled at the same edge as its address.
- R4: A write updates only the lanes whose `lane_n` bit is 0. Bit 0 selects bits 8:0 and bit 1 selects bits 17:9. The other lane keeps its stored value.
- R5: After a read, `dq_oe[i]` is 1 only for the lanes i whose `lane_n[i]` was 0 at the read edge. An unselected lane stays off in the output cycle.
- R6: A cycle with `ce_n`=1 sampled is a deselect. It changes no stored data, and `dq_oe` is 2'b00 in the cycle that follows it in the output pipeline.
- R7: `oe_n`=1 forces `dq_oe` to 2'b00 at once, without a clock edge. Returning `oe_n` to 0 restores drive for a pending read result in the same cycle.
- R8: A write sampled at edge n leaves `dq_oe` at 2'b00 between edges n+1 and n+2.
- R9: A read sampled at the edge right after a write to the same address returns the newly written lanes and the old values of the lanes that were not written.
- R10: A command with `lane_n`=2'b11 neither writes nor drives. For a read, `dq_oe` stays 2'b00. For a write, the stored word is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the control pipeline |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| lane_n | input | 2 | Active-low lane enables: bit 0 for bits 8:0, bit 1 for bits 17:9 |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | 18 | Write data, sampled with the address |
| dq_out | output | 18 | Registered read data |
| dq_oe | output | 2 | Per-lane drive enable for `dq_out` |

## Verification
The bench targets the following failure modes:
- **Read directly after a write to the same address.** A memory that read before committing the write would return stale lanes.
- **Partial-lane writes.** A write that ignored the lane mask would corrupt the neighbouring lane.
- **Single-lane and no-lane reads.** A design that drove the whole word on any read would show up here.
- **Write, deselect and no-lane cycles.** These catch a drive enable that leaked out of a non-read cycle, or a latency miscounted by one edge.
- **`oe_n` toggled between clock edges.** This exposes a design that registered the output enable instead of gating it combinationally.

// File: rtl/sram_pkg.sv
// Shared constants and types for the byte-lane SRAM.
// Assumes two lanes of nine bits each; the word width follows from them.
package sram_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANES-1:0] lane_vec_t;
endpackage

// File: rtl/sram_in_stage.sv
// Input stage: decodes the sampled command into per-lane write strobes
// (used in the sampling cycle) and registers the address and per-lane
// read flags for the output pipeline. Assumes inputs are stable at the edge.
module sram_in_stage
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  lane_vec_t         lane_n,
    output lane_vec_t         wr_lanes,
    output logic [ADDR_W-1:0] addr_q,
    output lane_vec_t         rd_lanes_q
);
    lane_vec_t rd_lanes;

    // Per-lane write and read strobes decoded from the command pins.
    always_comb begin
        wr_lanes = '0;
        rd_lanes = '0;
        if (rst_n && !ce_n) begin
            if (!we_n) wr_lanes = ~lane_n;
            else       rd_lanes = ~lane_n;
        end
    end

    // Capture the read address and lane flags at the sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            rd_lanes_q <= '0;
        end else begin
            addr_q     <= addr;
            rd_lanes_q <= rd_lanes;
        end
    end

    // R6
    deselect_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (rd_lanes_q == '0));

    // R10
    no_lane_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_n == '1) |=> (rd_lanes_q == '0));
endmodule

// File: rtl/sram_lane_bank.sv
// One byte lane of storage: commits a write on the sampling edge and
// loads the output register from the registered read address one edge
// later. Assumes a read and a write never share a sampling edge.
module sram_lane_bank
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [LANE_W-1:0] rd_data_q
);
    logic [LANE_W-1:0] mem [DEPTH];

    // Self-timed write: the word is stored on its sampling edge.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Output register fed from the address registered one edge earlier.
    always_ff @(posedge clk) begin
        rd_data_q <= mem[rd_addr];
    end
endmodule

// File: rtl/sram_out_stage.sv
// Output stage: pipelines the read-lane flags into the output cycle and
// gates them with the asynchronous active-low output enable.
// Assumes oe_n may change at any time between edges.
module sram_out_stage
    import sram_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lane_vec_t rd_lanes_q,
    input  logic      oe_n,
    output lane_vec_t dq_oe
);
    lane_vec_t lane_act_q;

    // Move the read flags into the cycle where their data is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) lane_act_q <= '0;
        else        lane_act_q <= rd_lanes_q;
    end

    // Combinational gating by output enable, no clock in the path.
    always_comb dq_oe = oe_n ? '0 : lane_act_q;

    // R5
    drive_only_read_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dq_oe & ~lane_act_q) == '0));
endmodule

// File: rtl/sram_byte_lane.sv
// Top level of the byte-lane pipelined SRAM. Ties the input stage, one
// storage bank per lane (generated) and the output stage together.
// Assumes the bus turnaround is planned by the user: a read result is
// driven in the cycle after its edge n+1.
module sram_byte_lane
    import sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [1:0]        lane_n,
    input  logic              oe_n,
    input  logic [17:0]       dq_in,
    output logic [17:0]       dq_out,
    output logic [1:0]        dq_oe
);
    lane_vec_t         wr_lanes;
    lane_vec_t         rd_lanes_q;
    logic [ADDR_W-1:0] addr_q;

    sram_in_stage #(.ADDR_W(ADDR_W)) in_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .ce_n       (ce_n),
        .we_n       (we_n),
        .lane_n     (lane_n),
        .wr_lanes   (wr_lanes),
        .addr_q     (addr_q),
        .rd_lanes_q (rd_lanes_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_bank #(.ADDR_W(ADDR_W)) bank_i (
            .clk       (clk),
            .wr_en     (wr_lanes[g]),
            .wr_addr   (addr),
            .wr_data   (dq_in[g*LANE_W +: LANE_W]),
            .rd_addr   (addr_q),
            .rd_data_q (dq_out[g*LANE_W +: LANE_W])
        );
    end

    sram_out_stage out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_lanes_q (rd_lanes_q),
        .oe_n       (oe_n),
        .dq_oe      (dq_oe)
    );

    // R8
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> ##1 (dq_oe == 2'b00));

    // R7
    oe_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (dq_oe == 2'b00));

    // R2
    read_drive_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && !oe_n) |=> ##1 (oe_n || (dq_oe == $past(~lane_n, 2))));
endmodule

// File: tb/sram_byte_lane_tb.sv
// Self-checking bench: directed corner cases followed by seeded random
// traffic, compared against a behavioural model held in the bench.
module sram_byte_lane_tb_top;
    localparam int AW = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          ce_n, we_n, oe_n;
    logic [1:0]    lane_n;
    logic [17:0]   dq_in;
    logic [17:0]   dq_out;
    logic [1:0]    dq_oe;

    int checks = 0;
    int errors = 0;

    logic [17:0] model [1 << AW];
    logic [1:0]  pend_lanes;
    logic [17:0] pend_data;
    string       pend_tag;
    logic [1:0]  exp_lanes;
    logic [17:0] exp_data;
    string       exp_tag;

    always #5 clk = ~clk;

    sram_byte_lane #(.ADDR_W(AW)) dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .ce_n   (ce_n),
        .we_n   (we_n),
        .lane_n (lane_n),
        .oe_n   (oe_n),
        .dq_in  (dq_in),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Merge a write into the model, honouring the lane mask.
    function automatic logic [17:0] merge(input logic [17:0] old, input logic [17:0] d, input logic [1:0] ln);
        logic [17:0] r;
        r = old;
        if (!ln[0]) r[8:0]  = d[8:0];
        if (!ln[1]) r[17:9] = d[17:9];
        return r;
    endfunction

    // Drive one command, clock it in, advance the model, check outputs.
    task automatic step(input logic c, input logic w, input logic [1:0] ln,
                        input logic [AW-1:0] a, input logic [17:0] d, input string tag);
        ce_n = c; we_n = w; lane_n = ln; addr = a; dq_in = d;
        @(posedge clk);
        exp_lanes = pend_lanes; exp_data = pend_data; exp_tag = pend_tag;
        if (!c && w) begin
            pend_lanes = ~ln; pend_data = model[a]; pend_tag = tag;
        end else begin
            pend_lanes = 2'b00; pend_data = '0; pend_tag = tag;
        end
        if (!c && !w) model[a] = merge(model[a], d, ln);
        @(negedge clk);
        check(dq_oe == exp_lanes, exp_tag, 32'(dq_oe), 32'(exp_lanes));
        if (exp_lanes[0]) check(dq_out[8:0] == exp_data[8:0], exp_tag, 32'(dq_out[8:0]), 32'(exp_data[8:0]));
        if (exp_lanes[1]) check(dq_out[17:9] == exp_data[17:9], exp_tag, 32'(dq_out[17:9]), 32'(exp_data[17:9]));
    endtask

    task automatic idle(input string tag);
        step(1'b1, 1'b1, 2'b11, '0, '0, tag);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        pend_lanes = '0; pend_data = '0; pend_tag = "R1";
        rst_n = 1'b0; oe_n = 1'b0; ce_n = 1'b1; we_n = 1'b1;
        lane_n = 2'b11; addr = '0; dq_in = '0;
        repeat (3) @(negedge clk);
        // R1: no drive during reset
        check(dq_oe == 2'b00, "R1", 32'(dq_oe), 0);
        rst_n = 1'b1;
        idle("R1");
        idle("R1");

        // Prefill the addresses used later so every read has a known value.
        for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 2'b00, AW'(i), 18'(i * 18'h1111 + 18'h5), "R3");
        idle("R8");
        idle("R8");

        // R3 full-word write, then R9 read on the very next edge.
        step(1'b0, 1'b0, 2'b00, 10'd3, 18'h2A5C3, "R8");
        step(1'b0, 1'b1, 2'b00, 10'd3, '0, "R9");
        idle("R3");
        idle("R6");
        // R4 lower-only write, then read of the full word.
        step(1'b0, 1'b0, 2'b10, 10'd3, 18'h3FFFF, "R8");
        step(1'b0, 1'b1, 2'b00, 10'd3, '0, "R4");
        idle("R4");
        // R4 upper-only write.
        step(1'b0, 1'b0, 2'b01, 10'd4, 18'h00000, "R8");
        step(1'b0, 1'b1, 2'b00, 10'd4, '0, "R4");
        idle("R4");
        // R5 single-lane reads.
        step(1'b0, 1'b1, 2'b10, 10'd5, '0, "R5");
        step(1'b0, 1'b1, 2'b01, 10'd6, '0, "R5");
        idle("R5");
        // R6 deselect carrying write-like pins stores nothing.
        step(1'b1, 1'b0, 2'b00, 10'd7, 18'h12345, "R6");
        step(1'b0, 1'b1, 2'b00, 10'd7, '0, "R6");
        idle("R6");
        // R10 no-lane write and no-lane read.
        step(1'b0, 1'b0, 2'b11, 10'd8, 18'h0F0F0, "R10");
        step(1'b0, 1'b1, 2'b11, 10'd8, '0, "R10");
        step(1'b0, 1'b1, 2'b00, 10'd8, '0, "R10");
        idle("R10");

        // R7 asynchronous output enable on a pending read result.
        step(1'b0, 1'b1, 2'b00, 10'd9, '0, "R7");
        ce_n = 1'b1; we_n = 1'b1; lane_n = 2'b11;
        @(posedge clk);
        exp_lanes = pend_lanes; exp_data = pend_data;
        pend_lanes = '0; pend_data = '0; pend_tag = "R7";
        #2;
        check(dq_oe == 2'b11, "R7", 32'(dq_oe), 32'h3);
        oe_n = 1'b1;
        #1;
        check(dq_oe == 2'b00, "R7", 32'(dq_oe), 0);
        oe_n = 1'b0;
        #1;
        check(dq_oe == 2'b11, "R7", 32'(dq_oe), 32'h3);
        check(dq_out == exp_data, "R7", 32'(dq_out), 32'(exp_data));
        @(negedge clk);
        idle("R6");

        // R2 random traffic over a small address window.
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] op;
            logic [1:0] ln;
            logic [AW-1:0] a;
            op = 3'($urandom_range(0, 5));
            ln = 2'($urandom_range(0, 3));
            a  = AW'($urandom_range(0, 15));
            case (op)
                3'd0, 3'd1: step(1'b0, 1'b0, ln, a, 18'($urandom), "R8");
                3'd2, 3'd3, 3'd4: step(1'b0, 1'b1, ln, a, '0, "R2");
                default: step(1'b1, 1'($urandom_range(0, 1)), ln, a, 18'($urandom), "R6");
            endcase
        end
        idle("R2");
        idle("R2");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule